// File: doc/BRIEF.md
# Microcoded Instruction-Fetch Sequencer

This block steps a processor through the four states of an instruction fetch. It does not hard-wire those states. A small constant micro-memory, addressed by the current state number, holds one micro-word per state. Each micro-word carries three fields:

- a datapath control word;
- a selector that names which external condition to examine;
- a pair of successor addresses, one for the condition being false and one for it being true.

A waiting state is therefore written in microcode as a conditional loop back to itself, and is not built as extra logic.

The fetch runs in a fixed order:

- **T1** routes the program counter through the source multiplexer, the ALU (in pass-B mode) and the destination multiplexer into the address register, which drives the address bus.
- **T2** raises the memory read strobe and bumps the program counter. It then loops on itself until the memory reports ready.
- **T3** leaves the bus to the memory.
- **T4** routes the incoming data bus into the instruction register and returns to T1.

The selected micro-word is captured in a micro-word register on every clock. The control outputs therefore lag the state address by exactly one cycle.

The block has no streaming data interface. All of its pins are plain control and status signals: the memory-ready condition, the registered control word and the current state.

Top module: `fetch_useq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, state reads 0 (T1) and ctrl_word reads all zeros.
- R2: The micro-memory address is the state number (T1=0, T2=1, T3=2, T4=3). After each rising clock edge, ctrl_word holds the output field of the micro-word at the address that state showed before that edge.
- R3: From T1 the sequencer always moves to T2. The T1 output field is 14'h2978. Field layout, from MSB to LSB:
  - bit 13: pc_out
  - bit 12: pc_inc
  - bit 11: src_sel
  - bits 10:6: alu_fn, where pass-B = 5'b00101
  - bit 5: dst_sel
  - bit 4: adr_load
  - bit 3: adr_drive
  - bit 2: rd_strobe
  - bit 1: ir_load
  - bit 0: din_route
- R4: In T2, with mem_ready low at the clock edge, the sequencer stays in T2 for as many cycles as ready stays low.
- R5: In T2, with mem_ready high at the clock edge, the sequencer moves to T3.
- R6: The T2 output field is 14'h100C, which asserts pc_inc, adr_drive and rd_strobe.
- R7: From T3 the sequencer always moves to T4. The T3 output field is all zeros.
- R8: From T4 the sequencer always moves to T1. The T4 output field is 14'h0003, which asserts ir_load and din_route.
- R9: mem_ready has no effect on the sequence in T1, T3 or T4.
- R10: ir_load and adr_load are never asserted together in ctrl_word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ready | input | 1 | Memory ready condition, examined by test code 1 |
| ctrl_word | output | 14 | Registered datapath control word |
| state | output | 2 | Current state / micro-memory address |

## Verification
The in-RTL assertions check the following on every cycle:
- each state's successor, including the ready-gated loop and exit in T2;
- the one-cycle lag between a state and its read or load strobes;
- the exclusivity of the two register loads.

Only the bench's scenarios can show three further behaviours:
- the exact control word for each state;
- the reset contents of the micro-word register;
- that mem_ready toggling in the other three states leaves the sequence unchanged.

The bench covers long waits, immediate readiness and pseudo-random ready patterns.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int ALU_FN_W   = 5;
  localparam int STATE_W    = 2;
  localparam int NUM_STATES = 1 << STATE_W;
  localparam int N_COND     = 1;
  localparam int TEST_W     = $clog2(N_COND + 1);

  localparam logic [ALU_FN_W-1:0] ALU_PASS_B = 5'b00101;

  typedef logic [STATE_W-1:0] st_t;
  localparam st_t ST_T1 = 2'd0;
  localparam st_t ST_T2 = 2'd1;
  localparam st_t ST_T3 = 2'd2;
  localparam st_t ST_T4 = 2'd3;

  // test selector: 0 = unconditional, k = condition k-1
  localparam logic [TEST_W-1:0] TST_NONE  = '0;
  localparam logic [TEST_W-1:0] TST_READY = 1'b1;

  typedef struct packed {
    logic                pc_out;
    logic                pc_inc;
    logic                src_sel;
    logic [ALU_FN_W-1:0] alu_fn;
    logic                dst_sel;
    logic                adr_load;
    logic                adr_drive;
    logic                rd_strobe;
    logic                ir_load;
    logic                din_route;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    ctrl_t             out_f;
    logic [TEST_W-1:0] test_f;
    st_t               next_f;
    st_t               next_t;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  // constant micro-program for the fetch cycle
  function automatic uword_t ucode(input st_t addr);
    uword_t w;
    w = '0;
    case (addr)
      ST_T1: begin
        w.out_f.pc_out    = 1'b1;
        w.out_f.src_sel   = 1'b1;
        w.out_f.alu_fn    = ALU_PASS_B;
        w.out_f.dst_sel   = 1'b1;
        w.out_f.adr_load  = 1'b1;
        w.out_f.adr_drive = 1'b1;
        w.test_f          = TST_NONE;
        w.next_f          = ST_T2;
        w.next_t          = ST_T2;
      end
      ST_T2: begin
        w.out_f.pc_inc    = 1'b1;
        w.out_f.adr_drive = 1'b1;
        w.out_f.rd_strobe = 1'b1;
        w.test_f          = TST_READY;
        w.next_f          = ST_T2;
        w.next_t          = ST_T3;
      end
      ST_T3: begin
        w.test_f = TST_NONE;
        w.next_f = ST_T4;
        w.next_t = ST_T4;
      end
      default: begin
        w.out_f.ir_load   = 1'b1;
        w.out_f.din_route = 1'b1;
        w.test_f          = TST_NONE;
        w.next_f          = ST_T1;
        w.next_t          = ST_T1;
      end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fseq_urom.sv
module fseq_urom
  import fseq_pkg::*;
(
  input  st_t    addr,
  output uword_t word
);
  uword_t table_w [NUM_STATES];

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_loc
    assign table_w[g] = ucode(st_t'(g));
  end

  assign word = table_w[addr];
endmodule

// File: rtl/fseq_next.sv
module fseq_next
  import fseq_pkg::*;
(
  input  logic [TEST_W-1:0] test_sel,
  input  st_t               succ_false,
  input  st_t               succ_true,
  input  logic [N_COND-1:0] cond_in,
  output st_t               succ
);
  logic hit;

  always_comb begin
    hit = (test_sel == TST_NONE);
    for (int i = 0; i < N_COND; i++) begin
      if (test_sel == TEST_W'(i + 1)) hit = cond_in[i];
    end
    succ = hit ? succ_true : succ_false;
  end
endmodule

// File: rtl/fseq_state.sv
module fseq_state
  import fseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  st_t  succ,
  input  logic ready_mon,
  output st_t  cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= ST_T1;
    else        cur <= succ;
  end

  assert_t1_to_t2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur == ST_T1 |=> cur == ST_T2);
  assert_t2_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_T2 && !ready_mon) |=> cur == ST_T2);
  assert_t2_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_T2 && ready_mon) |=> cur == ST_T3);
  assert_t3_to_t4_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cur == ST_T3 |=> cur == ST_T4);
  assert_t4_to_t1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur == ST_T4 |=> cur == ST_T1);
endmodule

// File: rtl/fseq_uwreg.sv
module fseq_uwreg
  import fseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t out_d,
  output ctrl_t out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assert_load_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_q.ir_load, out_q.adr_load}));
endmodule

// File: rtl/fetch_useq.sv
module fetch_useq
  import fseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ready,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [STATE_W-1:0] state
);
  st_t    cur_st;
  st_t    succ_st;
  uword_t rom_word;
  ctrl_t  ctrl_q;

  fseq_urom u_urom (
    .addr (cur_st),
    .word (rom_word)
  );

  fseq_next u_next (
    .test_sel   (rom_word.test_f),
    .succ_false (rom_word.next_f),
    .succ_true  (rom_word.next_t),
    .cond_in    (mem_ready),
    .succ       (succ_st)
  );

  fseq_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .succ      (succ_st),
    .ready_mon (mem_ready),
    .cur       (cur_st)
  );

  fseq_uwreg u_uwreg (
    .clk   (clk),
    .rst_n (rst_n),
    .out_d (rom_word.out_f),
    .out_q (ctrl_q)
  );

  assign ctrl_word = ctrl_q;
  assign state     = cur_st;

  assert_rd_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_st == ST_T2 |=> ctrl_q.rd_strobe);
  assert_ir_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_st == ST_T4 |=> (ctrl_q.ir_load && !ctrl_q.pc_out));
  assert_adr_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_st == ST_T1 |=> (ctrl_q.adr_load && ctrl_q.alu_fn == ALU_PASS_B));
endmodule

// File: tb/fetch_useq_bench.sv
module fetch_useq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_ready = 1'b0;
  logic [13:0] ctrl_word;
  logic [1:0]  state;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int     m_state = 0;
  int     m_ctrl = 0;
  string  m_tag = "R1";

  fetch_useq u_fetch_useq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ready (mem_ready),
    .ctrl_word (ctrl_word),
    .state     (state)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // expected output field per state, from R3/R6/R7/R8
  function automatic int word_of(input int s);
    case (s)
      0: return 'h2978;
      1: return 'h100C;
      2: return 'h0000;
      default: return 'h0003;
    endcase
  endfunction

  function automatic string word_tag(input int s);
    case (s)
      0: return "R3";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0;
      m_ctrl  <= 0;
      m_tag   <= "R1";
    end else begin
      m_ctrl <= word_of(m_state);
      case (m_state)
        0: begin m_state <= 1; m_tag <= mem_ready ? "R9" : "R3"; end
        1: begin
          if (mem_ready) begin m_state <= 2; m_tag <= "R5"; end
          else           begin m_state <= 1; m_tag <= "R4"; end
        end
        2: begin m_state <= 3; m_tag <= mem_ready ? "R9" : "R7"; end
        default: begin m_state <= 0; m_tag <= mem_ready ? "R9" : "R8"; end
      endcase
    end
  end

  task automatic compare();
    string wt;
    tests++;
    if (int'(state) != m_state) begin
      fails++;
      $display("FAIL %s state actual=%0d expected=%0d", m_tag, state, m_state);
    end
    tests++;
    wt = (!rst_n || m_tag == "R1") ? "R1" : "R2";
    if (int'(ctrl_word) != m_ctrl) begin
      fails++;
      $display("FAIL %s/%s ctrl_word actual=%h expected=%h", wt,
               word_tag((m_state + 3) % 4), ctrl_word, m_ctrl[13:0]);
    end
    tests++;
    if (ctrl_word[1] && ctrl_word[4]) begin
      fails++;
      $display("FAIL R10 ctrl_word actual=%h expected=no double load", ctrl_word);
    end
  endtask

  task automatic step(input logic rdy);
    @(negedge clk);
    compare();
    mem_ready = rdy;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1);
    rst_n = 1'b1;
    // R5/R9: ready always high
    for (int i = 0; i < 16; i++) step(1'b1);
    // R4: long wait in T2
    for (int i = 0; i < 14; i++) step(1'b0);
    for (int i = 0; i < 8; i++) step(1'b1);
    // R9 and mixed: pseudo-random ready
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0]);
    end
    // R1: reset applied mid-sequence
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 2; i++) step(1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) step(i[0]);
    step(1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule